// File: doc/BRIEF.md
# Shared Address/Data External Bus Port Controller

This block runs external memory transfers over a single 16-bit port whose pins carry first an address and then data, or data alone. An internal client raises a start pulse with an address, write data, a size (byte or word) and a direction. The controller then steps the port through the phases that the selected bus mode requires. It sets the per-pin output enable and raises an address latch strobe so that external logic can hold the address. It finishes with a one-clock completion pulse and, for a read, the assembled read data.

The bus mode comes from the same pins. While reset is held, the controller never drives the port and keeps sampling it. Pins read high unless something pulls them low. The value present on the last clock edge of reset becomes the bus configuration. The upper half of that value is also kept as a read-only strap byte. Pin 0 selects address/data sharing (high = shared, low = data only). Pin 1 selects the bus width (high = 16-bit, low = 8-bit). On an 8-bit bus a word is moved as two byte transfers, the low byte first.

Top module: `xbus_port_ctrl`

## Requirements
- R1: While `rst_n` is low, `port_oe` is all zero. `cfg_bus` = {pin1, pin0} and `strap_hi` = pins 15..8, as sampled on the last rising edge with `rst_n` low. Both then stay unchanged until the next reset.
- R2: In shared mode (`cfg_bus[0]`=1), each transfer beat starts with one address cycle. In that cycle `port_out` carries the beat address, `port_oe` is all ones and `ale` is 1. `ale` is 0 in every other cycle.
- R3: A shared-mode read beat puts exactly one cycle after the address cycle with `port_oe`=0 and `ale`=0. The next cycle is the capture cycle, also with `port_oe`=0, and `port_in` is sampled at its closing edge.
- R4: A shared-mode write beat drives the write data in the cycle directly after the address cycle, with `ale`=0.
- R5: In data-only mode (`cfg_bus[0]`=0), each beat is a single data cycle, `ale` stays 0, and `ext_addr` carries the beat address. In every busy cycle `ext_addr` shows the current beat address, and it is 0 when idle.
- R6: On an 8-bit bus (`cfg_bus[1]`=0), data cycles use only pins 7..0. `port_oe[15:8]` is 0 in every data cycle, and in data-only 8-bit mode it is 0 at all times. A byte access takes one beat and returns {8'h00, pins 7..0}.
- R7: On an 8-bit bus, a word access runs two beats. The first uses the address with bit 0 cleared and carries bits 7..0. The second uses bit 0 set and carries bits 15..8. Reads are assembled into `rdata` in that order.
- R8: On a 16-bit bus, a byte access uses lane pins 7..0 when address bit 0 is 0 and pins 15..8 when it is 1. A write drives `req_wdata[7:0]` on that lane only. A read returns the lane in `rdata[7:0]` with zeros above. A word access uses all pins at the address with bit 0 cleared.
- R9: `done` is high for exactly one cycle, the cycle after the final data cycle, and `rdata` is valid in that cycle. A new request may be accepted in that same cycle.
- R10: `req_valid` and the other request inputs are ignored while a transfer is in progress.
- R11: When idle, `port_oe` is 0, `ale` is 0 and `ext_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; strap sampling window |
| req_valid | input | 1 | Start pulse for a transfer, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr | input | 16 | Intra-segment address |
| req_wdata | input | 16 | Write data (a byte in bits 7..0) |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, valid with `done` |
| port_in | input | 16 | Port pin input values |
| port_out | output | 16 | Port pin output values |
| port_oe | output | 16 | Per-pin output enable |
| ale | output | 1 | Address latch strobe |
| ext_addr | output | 16 | Beat address for separate address pins |
| cfg_bus | output | 2 | Strapped mode {width16, shared} |
| strap_hi | output | 8 | Strapped upper pin byte |

## Verification
The assertions check, on every cycle, the properties that hold at any time: the strobe only appears with the whole port driven and never in two cycles in a row, the turnaround cycle floats the port, the data-only modes never raise the strobe, the high byte stays released in data-only 8-bit mode, idle means released, the completion pulse lasts one cycle, and the strapped mode stays fixed outside reset. Only the bench's scenarios can show the order of phases, the byte-beat order and assembly of split words, lane selection by address bit 0, strap capture for each of the four modes, and that a request arriving mid-transfer leaves the sequence untouched. The bench checks these against a queue of expected cycles.

// File: rtl/xbus_pkg.sv
// Shared types for the external bus port controller.
// Assumes the intra-segment address and the port have the same width.
package xbus_pkg;

    // Sequencer phase: one value per bus clock of a beat.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_TURN = 2'd2,
        PH_DATA = 2'd3
    } phase_e;

    // Strapped bus configuration.
    typedef struct packed {
        logic bus16;   // 1 = full-width data bus, 0 = byte-wide data bus
        logic mux;     // 1 = address shares the data pins, 0 = data only
    } bus_cfg_t;

    localparam int LANE_W = 8;

endpackage

// File: rtl/xbus_strap.sv
// Captures the bus mode straps from the port pins while reset is held.
// Assumes the pins read high by default and that the value present on the
// last clock edge of reset is the intended one. Holds it afterwards.
module xbus_strap #(
    parameter int DW = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             mode_pins,
    input  logic [DW-1:DW/2]       hi_pins,
    output xbus_pkg::bus_cfg_t     cfg,
    output logic [DW/2-1:0]        strap_hi
);

    // Track the pins during reset, freeze them once reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.mux   <= mode_pins[0];
            cfg.bus16 <= mode_pins[1];
            strap_hi  <= hi_pins;
        end
    end

endmodule

// File: rtl/xbus_seq.sv
// Transfer sequencer: accepts a request when idle, latches it, and steps
// through address, turnaround and data phases for one or two beats.
// Assumes a word on a byte-wide bus splits into exactly two beats.
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  bus_cfg_t        cfg,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic            req_word,
    input  logic [DW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    output phase_e          phase,
    output logic            beat,
    output logic            cur_write,
    output logic            cur_word,
    output logic [DW-1:0]   beat_addr,
    output logic [DW-1:0]   cur_wdata,
    output logic            final_data
);

    logic [DW-1:0] addr_q;
    logic          split;

    // A word needs a second beat only on the byte-wide bus.
    assign split      = cur_word && !cfg.bus16;
    assign final_data = (phase == PH_DATA) && !(split && !beat);
    // Word beats use an even base address with the beat number in bit 0.
    assign beat_addr  = cur_word ? {addr_q[DW-1:1], beat} : addr_q;

    // Phase stepping and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            beat      <= 1'b0;
            cur_write <= 1'b0;
            cur_word  <= 1'b0;
            addr_q    <= '0;
            cur_wdata <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        cur_write <= req_write;
                        cur_word  <= req_word;
                        addr_q    <= req_addr;
                        cur_wdata <= req_wdata;
                        beat      <= 1'b0;
                        phase     <= cfg.mux ? PH_ADDR : PH_DATA;
                    end
                end
                PH_ADDR: phase <= cur_write ? PH_DATA : PH_TURN;
                PH_TURN: phase <= PH_DATA;
                PH_DATA: begin
                    if (split && !beat) begin
                        beat  <= 1'b1;
                        phase <= cfg.mux ? PH_ADDR : PH_DATA;
                    end else begin
                        phase <= PH_IDLE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/xbus_drive.sv
// Port driver: decodes the current phase into pin values, per-pin output
// enables, the address latch strobe and the separate address output.
// Assumes DW is a multiple of the lane width and at least two lanes wide.
module xbus_drive
    import xbus_pkg::*;
#(
    parameter int DW = 16
) (
    input  bus_cfg_t        cfg,
    input  phase_e          phase,
    input  logic            beat,
    input  logic            write,
    input  logic            word,
    input  logic [DW-1:0]   beat_addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   port_out,
    output logic [DW-1:0]   port_oe,
    output logic            ale,
    output logic [DW-1:0]   ext_addr
);

    localparam int LANES = DW / LANE_W;
    localparam int SELW  = (LANES > 1) ? $clog2(LANES) : 1;

    logic [LANES-1:0]  lane_en;
    logic [DW-1:0]     lane_data;
    logic [DW-1:0]     lane_oe;
    logic [SELW-1:0]   sel;
    logic [LANE_W-1:0] narrow_byte;

    assign sel = beat_addr[SELW-1:0];
    // On the byte-wide bus the second word beat carries the upper byte.
    assign narrow_byte = (word && beat) ? wdata[2*LANE_W-1:LANE_W]
                                        : wdata[LANE_W-1:0];

    // Per-lane enable and data for the write data phase.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_en[g] = cfg.bus16 ? (word || (sel == SELW'(g))) : (g == 0);
        assign lane_data[g*LANE_W +: LANE_W] =
            cfg.bus16 ? (word ? wdata[g*LANE_W +: LANE_W] : wdata[LANE_W-1:0])
                      : ((g == 0) ? narrow_byte : '0);
        assign lane_oe[g*LANE_W +: LANE_W] = {LANE_W{lane_en[g]}};
    end

    // Pin values and enables for the current phase.
    always_comb begin
        port_out = '0;
        port_oe  = '0;
        ale      = 1'b0;
        unique case (phase)
            PH_ADDR: begin
                port_out = beat_addr;
                port_oe  = '1;
                ale      = cfg.mux;
            end
            PH_DATA: begin
                if (write) begin
                    port_out = lane_data;
                    port_oe  = lane_oe;
                end
            end
            default: ;
        endcase
    end

    // Separate address output follows the beat while busy.
    assign ext_addr = (phase != PH_IDLE) ? beat_addr : '0;

endmodule

// File: rtl/xbus_capture.sv
// Read capture: samples the port at the end of each read data cycle,
// assembles split words, and raises the completion pulse.
// Assumes the sequencer marks the final data cycle of a transfer.
module xbus_capture
    import xbus_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus16,
    input  phase_e          phase,
    input  logic            beat,
    input  logic            write,
    input  logic            word,
    input  logic [$clog2(DW/LANE_W)-1:0] sel,
    input  logic            final_data,
    input  logic [DW-1:0]   port_in,
    output logic [DW-1:0]   rdata,
    output logic            done
);

    logic [LANE_W-1:0] picked;

    // Byte lane selected by the low address bits.
    assign picked = port_in[LANE_W*sel +: LANE_W];

    // Capture read data and pulse completion after the last data cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            done  <= 1'b0;
        end else begin
            done <= final_data;
            if (phase == PH_DATA && !write) begin
                if (bus16) begin
                    rdata <= word ? port_in : DW'(picked);
                end else if (word && beat) begin
                    rdata[2*LANE_W-1:LANE_W] <= port_in[LANE_W-1:0];
                end else begin
                    rdata <= DW'(port_in[LANE_W-1:0]);
                end
            end
        end
    end

endmodule

// File: rtl/xbus_port_ctrl.sv
// Top of the external bus port controller. Wires the strap capture, the
// sequencer, the pin driver and the read capture together.
// Assumes the port width equals the intra-segment address width.
module xbus_port_ctrl #(
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic            req_word,
    input  logic [DW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    output logic            done,
    output logic [DW-1:0]   rdata,
    input  logic [DW-1:0]   port_in,
    output logic [DW-1:0]   port_out,
    output logic [DW-1:0]   port_oe,
    output logic            ale,
    output logic [DW-1:0]   ext_addr,
    output logic [1:0]      cfg_bus,
    output logic [DW/2-1:0] strap_hi
);

    import xbus_pkg::*;

    localparam int SELW = $clog2(DW / LANE_W);

    bus_cfg_t      cfg;
    phase_e        phase_q;
    logic          beat;
    logic          cur_write;
    logic          cur_word;
    logic [DW-1:0] beat_addr;
    logic [DW-1:0] cur_wdata;
    logic          final_data;

    assign cfg_bus = {cfg.bus16, cfg.mux};

    xbus_strap #(.DW(DW)) u_strap (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_pins (port_in[1:0]),
        .hi_pins   (port_in[DW-1:DW/2]),
        .cfg       (cfg),
        .strap_hi  (strap_hi)
    );

    xbus_seq #(.DW(DW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_word   (req_word),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .phase      (phase_q),
        .beat       (beat),
        .cur_write  (cur_write),
        .cur_word   (cur_word),
        .beat_addr  (beat_addr),
        .cur_wdata  (cur_wdata),
        .final_data (final_data)
    );

    xbus_drive #(.DW(DW)) u_drive (
        .cfg       (cfg),
        .phase     (phase_q),
        .beat      (beat),
        .write     (cur_write),
        .word      (cur_word),
        .beat_addr (beat_addr),
        .wdata     (cur_wdata),
        .port_out  (port_out),
        .port_oe   (port_oe),
        .ale       (ale),
        .ext_addr  (ext_addr)
    );

    xbus_capture #(.DW(DW)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus16      (cfg.bus16),
        .phase      (phase_q),
        .beat       (beat),
        .write      (cur_write),
        .word       (cur_word),
        .sel        (beat_addr[SELW-1:0]),
        .final_data (final_data),
        .port_in    (port_in),
        .rdata      (rdata),
        .done       (done)
    );

endmodule

// File: rtl/xbus_port_chk.sv
// Property checker for the external bus port controller, bound to the top.
// Assumes the phase encoding of the shared package.
module xbus_port_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ale,
    input logic [DW-1:0] port_oe,
    input logic          done,
    input logic [1:0]    cfg_bus,
    input logic [1:0]    phase
);

    // R2
    ale_full_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (port_oe == {DW{1'b1}}));

    // R2
    ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // R3
    turn_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd2) |-> (port_oe == '0 && !ale));

    // R5
    data_only_no_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_bus[0] |-> !ale);

    // R6
    narrow_hi_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bus == 2'b00) |-> (port_oe[DW-1:DW/2] == '0));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd0) |-> (port_oe == '0 && !ale));

    // R1
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(cfg_bus));

endmodule

bind xbus_port_ctrl xbus_port_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ale     (ale),
    .port_oe (port_oe),
    .done    (done),
    .cfg_bus (cfg_bus),
    .phase   (phase_q)
);

// File: tb/tb_xbus_port_ctrl.sv
// Bench: builds a queue of expected per-cycle port states for each request
// and compares the design against it at every falling edge.
module tb_xbus_port_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_word = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        done;
    logic [15:0] rdata;
    logic [15:0] port_in = 16'hFFFF;
    logic [15:0] port_out;
    logic [15:0] port_oe;
    logic        ale;
    logic [15:0] ext_addr;
    logic [1:0]  cfg_bus;
    logic [7:0]  strap_hi;

    always #5 clk = ~clk;

    xbus_port_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
        .done(done), .rdata(rdata), .port_in(port_in), .port_out(port_out),
        .port_oe(port_oe), .ale(ale), .ext_addr(ext_addr), .cfg_bus(cfg_bus),
        .strap_hi(strap_hi)
    );

    typedef struct {
        logic [15:0] oe;
        logic [15:0] out;
        logic [15:0] ext;
        logic [15:0] pin;
        logic [15:0] rdv;
        logic        ale;
        logic        done;
        logic        chk_rd;
        string       tag;
    } rec_t;

    rec_t        q[$];
    int          checks = 0;
    int          fails = 0;
    logic [15:0] idle_pin = 16'hFFFF;
    string       idle_tag = "R1";
    logic        m_mux = 1'b1;
    logic        m_bus16 = 1'b1;
    logic        noise_on = 1'b0;
    logic        noise_wr = 1'b0;
    logic        noise_wd = 1'b0;
    logic        finished = 1'b0;

    function automatic rec_t mk(logic [15:0] oe, logic [15:0] out, logic [15:0] ext,
                                logic [15:0] pin, logic a, string tag);
        rec_t r;
        r.oe = oe; r.out = out; r.ext = ext; r.pin = pin; r.rdv = '0;
        r.ale = a; r.done = 1'b0; r.chk_rd = 1'b0; r.tag = tag;
        return r;
    endfunction

    // One cycle: pop the expected state, drive pins, compare outputs.
    task automatic step();
        rec_t r;
        @(negedge clk);
        if (q.size() > 0) r = q.pop_front();
        else r = mk(16'h0, 16'h0, 16'h0, idle_pin, 1'b0, idle_tag);
        port_in = r.pin;
        checks++;
        if (port_oe !== r.oe || (port_out & port_oe) !== r.out || ale !== r.ale ||
            ext_addr !== r.ext || done !== r.done || (r.chk_rd && rdata !== r.rdv)) begin
            fails++;
            $display("FAIL %s: oe=%h out=%h ale=%b ext=%h done=%b rdata=%h expected oe=%h out=%h ale=%b ext=%h done=%b rdata=%h",
                     r.tag, port_oe, port_out & port_oe, ale, ext_addr, done, rdata,
                     r.oe, r.out, r.ale, r.ext, r.done, r.rdv);
        end
        // R10: a conflicting request held high while the transfer runs.
        if (noise_on) begin
            if (q.size() > 0) begin
                req_valid = 1'b1; req_write = ~noise_wr; req_word = ~noise_wd;
                req_addr = 16'h0F0F; req_wdata = 16'hBEEF;
            end else begin
                req_valid = 1'b0;
                noise_on = 1'b0;
            end
        end
    endtask

    // Issue one transfer and queue the cycles it must produce.
    task automatic issue(input logic wr, input logic wd, input logic [15:0] a,
                         input logic [15:0] wdat, input logic [15:0] rdv,
                         input logic noisy);
        rec_t r;
        int nb;
        logic [15:0] exp_rd;
        nb = (wd && !m_bus16) ? 2 : 1;
        while (q.size() > 0) step();
        req_valid = 1'b1; req_write = wr; req_word = wd;
        req_addr = a; req_wdata = wdat;
        for (int b = 0; b < nb; b++) begin
            logic [15:0] ba;
            logic [15:0] oe;
            logic [15:0] dv;
            logic [15:0] pin;
            string tg;
            ba = wd ? {a[15:1], b[0]} : a;
            if (m_mux) begin
                q.push_back(mk(16'hFFFF, ba, ba, idle_pin, 1'b1, "R2"));
                if (!wr) q.push_back(mk(16'h0, 16'h0, ba, idle_pin, 1'b0, "R3"));
            end
            if (!m_bus16) tg = wd ? "R7" : "R6";
            else if (!wd) tg = "R8";
            else if (!m_mux) tg = "R5";
            else tg = wr ? "R4" : "R3";
            if (m_bus16) begin
                if (wd) begin oe = 16'hFFFF; dv = wdat; end
                else if (a[0]) begin oe = 16'hFF00; dv = {wdat[7:0], 8'h00}; end
                else begin oe = 16'h00FF; dv = {8'h00, wdat[7:0]}; end
                pin = rdv;
            end else begin
                oe = 16'h00FF;
                dv = {8'h00, (wd && b == 1) ? wdat[15:8] : wdat[7:0]};
                pin = (b == 0) ? {8'h77, rdv[7:0]} : {8'h88, rdv[15:8]};
            end
            if (wr) q.push_back(mk(oe, dv, ba, idle_pin, 1'b0, tg));
            else    q.push_back(mk(16'h0, 16'h0, ba, pin, 1'b0, tg));
        end
        if (wd) exp_rd = rdv;
        else if (m_bus16 && a[0]) exp_rd = {8'h00, rdv[15:8]};
        else exp_rd = {8'h00, rdv[7:0]};
        r = mk(16'h0, 16'h0, 16'h0, idle_pin, 1'b0, (wd && !m_bus16) ? "R7" : "R9");
        r.done = 1'b1; r.chk_rd = !wr; r.rdv = exp_rd;
        q.push_back(r);
        noise_on = noisy; noise_wr = wr; noise_wd = wd;
        step();
        if (!noisy) req_valid = 1'b0;
    endtask

    // Reset with a strap pattern on the pins and check the captured mode.
    task automatic strap_reset(input logic [15:0] strap);
        while (q.size() > 0) step();
        rst_n = 1'b0; idle_pin = strap; idle_tag = "R1";
        repeat (3) step();
        rst_n = 1'b1;
        idle_pin = 16'h5A3C; idle_tag = "R11";
        step();
        m_mux = strap[0]; m_bus16 = strap[1];
        checks++;
        if (cfg_bus !== strap[1:0] || strap_hi !== strap[15:8]) begin
            fails++;
            $display("FAIL R1: cfg_bus=%b strap_hi=%h expected cfg_bus=%b strap_hi=%h",
                     cfg_bus, strap_hi, strap[1:0], strap[15:8]);
        end
    endtask

    task automatic traffic();
        issue(1'b1, 1'b1, 16'h1234, 16'hA1B2, 16'h0, 1'b0);
        issue(1'b0, 1'b1, 16'h2345, 16'h0,   16'hC3D4, 1'b0);
        issue(1'b1, 1'b0, 16'h3000, 16'h00E5, 16'h0, 1'b0);
        issue(1'b1, 1'b0, 16'h3001, 16'h00F6, 16'h0, 1'b0);
        step();
        issue(1'b0, 1'b0, 16'h4001, 16'h0,   16'h9A8B, 1'b0);
        issue(1'b0, 1'b0, 16'h4000, 16'h0,   16'h1C2D, 1'b0);
        issue(1'b0, 1'b1, 16'h5556, 16'h0,   16'h6E7F, 1'b1);
        issue(1'b1, 1'b1, 16'h6660, 16'h3141, 16'h0, 1'b1);
        repeat (2) step();
    endtask

    // R1 stability check after traffic.
    task automatic cfg_recheck(input logic [15:0] strap);
        checks++;
        if (cfg_bus !== strap[1:0] || strap_hi !== strap[15:8]) begin
            fails++;
            $display("FAIL R1: cfg_bus=%b strap_hi=%h expected cfg_bus=%b strap_hi=%h",
                     cfg_bus, strap_hi, strap[1:0], strap[15:8]);
        end
    endtask

    initial begin
        strap_reset(16'hFFFF); traffic(); cfg_recheck(16'hFFFF);
        strap_reset(16'hC3FE); traffic(); cfg_recheck(16'hC3FE);
        strap_reset(16'h5AFD); traffic(); cfg_recheck(16'h5AFD);
        strap_reset(16'h3CFC); traffic(); cfg_recheck(16'h3CFC);
        while (q.size() > 0) step();
        repeat (2) step();
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule